// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit status word of a small accumulator CPU. Five flags record results: carry, zero, overflow, negative and a break marker. Three flags steer the machine: interrupt mask, decimal arithmetic and index-X memory-to-memory mode. The block updates the result flags from ALU strobes and from a bit-test operand. It updates the control flags from decoded set and clear commands. It forces the break marker and the mask when an interrupt is taken, and it reloads the whole word when the status is pulled from the stack.

The port list has no streaming data path, so every pin is a plain, single-cycle control or status pin with no back-pressure. The decode logic asserts a strobe for exactly the cycle in which the matching update is due. The new value appears on the outputs after the next rising clock edge. `push_val` is combinational, so the stack write can take it in the same cycle that interrupt entry is signalled.

Top module: `psr_flags`

## Requirements
- R1: Bit layout of `status` is bit0 carry, bit1 zero, bit2 interrupt mask, bit3 decimal, bit4 break, bit5 index-X mode, bit6 overflow, bit7 negative. The individual flag outputs mirror these bits.
- R2: While `rst_n` is low, `status` is 8'h04: the mask is set and every other flag is clear.
- R3: When `upd_zn` is high and not gated by R6, the next zero flag is 1 exactly when `res_val` is 0, and the next negative flag equals `res_val[7]`.
- R4: When `upd_c` is high, the next carry equals `in_c`. This covers add, subtract, shift and rotate, and it applies whatever the decimal flag holds.
- R5: When `upd_v` is high and not gated by R6, the next overflow equals `in_v`.
- R6: When the decimal flag is currently 1 and `arith_op` is high, zero, negative and overflow keep their values, whatever the ALU strobes say.
- R7: When `bit_test` is high, the next negative equals `bit_opnd[7]` and the next overflow equals `bit_opnd[6]`. This takes priority over the ALU strobes for those two flags.
- R8: `cmd` codes: 1 set carry, 2 clear carry, 3 set mask, 4 clear mask, 5 set decimal, 6 clear decimal, 7 set index-X, 8 clear index-X, 9 clear overflow. Codes 0 and 10 to 15 change nothing. A command beats the ALU strobe and the bit test for the same flag.
- R9: While `irq_entry` is high, `push_val` equals `status` with bit4 replaced by `irq_is_brk`. On the next edge the break flag takes `irq_is_brk` and the mask becomes 1, overriding a clear-mask command.
- R10: `irq_ok` is high exactly when `irq_req` is high and the mask is 0.
- R11: When `pull_load` is high, all eight bits take `pull_data` on the next edge, ignoring every other input in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_c | input | 1 | Carry update strobe |
| in_c | input | 1 | Carry value from ALU |
| upd_zn | input | 1 | Zero/negative update strobe |
| res_val | input | 8 | Result byte for zero/negative |
| upd_v | input | 1 | Overflow update strobe |
| in_v | input | 1 | Overflow value from ALU |
| arith_op | input | 1 | Current update comes from add/subtract |
| bit_test | input | 1 | Bit-test update strobe |
| bit_opnd | input | 8 | Bit-test memory operand |
| cmd | input | 4 | Decoded set/clear command code |
| irq_entry | input | 1 | Interrupt entry in this cycle |
| irq_is_brk | input | 1 | Entry is the software break |
| irq_req | input | 1 | Pending maskable interrupt request |
| pull_load | input | 1 | Load whole word from stack |
| pull_data | input | 8 | Word pulled from stack |
| status | output | 8 | Registered status word |
| push_val | output | 8 | Word to push on interrupt entry |
| irq_ok | output | 1 | Maskable request accepted |
| flag_c | output | 1 | Carry |
| flag_z | output | 1 | Zero |
| flag_i | output | 1 | Interrupt mask |
| flag_d | output | 1 | Decimal mode |
| flag_t | output | 1 | Index-X mode |
| flag_v | output | 1 | Overflow |
| flag_n | output | 1 | Negative |

## Verification
Every flag is a register that is visible on `status`, so a wrong update shows on the ports exactly one edge after the stimulus that caused it. An error persists until the next write to that flag. A mask or break error also corrupts `push_val` and `irq_ok` in the same cycle, because both are computed from the stored word. The bench compares the full word every cycle against a model built from the priority rules. This exposes a wrong priority, a missed decimal gate or a swapped bit position at the first cycle that exercises it.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W = 8;
  localparam int B_C = 0;
  localparam int B_Z = 1;
  localparam int B_I = 2;
  localparam int B_D = 3;
  localparam int B_B = 4;
  localparam int B_T = 5;
  localparam int B_V = 6;
  localparam int B_N = 7;
  localparam logic [PSR_W-1:0] PSR_RST = 8'h04;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_SETC = 4'd1,
    CMD_CLRC = 4'd2,
    CMD_SETI = 4'd3,
    CMD_CLRI = 4'd4,
    CMD_SETD = 4'd5,
    CMD_CLRD = 4'd6,
    CMD_SETT = 4'd7,
    CMD_CLRT = 4'd8,
    CMD_CLRV = 4'd9
  } psr_cmd_e;
endpackage

// File: rtl/psr_cmd_decode.sv
module psr_cmd_decode
  import psr_pkg::*;
#(
  parameter int W = PSR_W
) (
  input  psr_cmd_e       cmd,
  output logic [W-1:0]   set_mask,
  output logic [W-1:0]   clr_mask
);
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    unique case (cmd)
      CMD_SETC: set_mask[B_C] = 1'b1;
      CMD_CLRC: clr_mask[B_C] = 1'b1;
      CMD_SETI: set_mask[B_I] = 1'b1;
      CMD_CLRI: clr_mask[B_I] = 1'b1;
      CMD_SETD: set_mask[B_D] = 1'b1;
      CMD_CLRD: clr_mask[B_D] = 1'b1;
      CMD_SETT: set_mask[B_T] = 1'b1;
      CMD_CLRT: clr_mask[B_T] = 1'b1;
      CMD_CLRV: clr_mask[B_V] = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    AST_CMD_EXCLUSIVE: assert ($countones({set_mask, clr_mask}) <= 1); // R8
  end
endmodule

// File: rtl/psr_result_path.sv
module psr_result_path
  import psr_pkg::*;
#(
  parameter int W  = PSR_W,
  parameter int DW = 8
) (
  input  logic          dec_mode,
  input  logic          arith_op,
  input  logic          upd_c,
  input  logic          in_c,
  input  logic          upd_zn,
  input  logic [DW-1:0] res_val,
  input  logic          upd_v,
  input  logic          in_v,
  input  logic          bit_test,
  input  logic [DW-1:0] bit_opnd,
  input  logic          irq_entry,
  input  logic          irq_is_brk,
  output logic [W-1:0]  upd_vec,
  output logic [W-1:0]  val_vec
);
  logic gate;
  assign gate = dec_mode & arith_op;

  always_comb begin
    upd_vec = '0;
    val_vec = '0;
    upd_vec[B_C] = upd_c;
    val_vec[B_C] = in_c;
    upd_vec[B_Z] = upd_zn & ~gate;
    val_vec[B_Z] = (res_val == '0);
    upd_vec[B_B] = irq_entry;
    val_vec[B_B] = irq_is_brk;
    if (bit_test) begin
      upd_vec[B_V] = 1'b1;
      val_vec[B_V] = bit_opnd[DW-2];
      upd_vec[B_N] = 1'b1;
      val_vec[B_N] = bit_opnd[DW-1];
    end else begin
      upd_vec[B_V] = upd_v & ~gate;
      val_vec[B_V] = in_v;
      upd_vec[B_N] = upd_zn & ~gate;
      val_vec[B_N] = res_val[DW-1];
    end
  end

  always_comb begin
    AST_DEC_NO_ZUPD: assert (!(gate && upd_vec[B_Z])); // R6
  end
endmodule

// File: rtl/psr_flag_cell.sv
module psr_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ld,
  input  logic ld_val,
  input  logic set,
  input  logic clr,
  input  logic upd,
  input  logic upd_val,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (ld)    q <= ld_val;
    else if (set)   q <= 1'b1;
    else if (clr)   q <= 1'b0;
    else if (upd)   q <= upd_val;
  end

  AST_CELL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> q == $past(ld_val)); // R11
endmodule

// File: rtl/psr_flags.sv
module psr_flags
  import psr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_c,
  input  logic          in_c,
  input  logic          upd_zn,
  input  logic [DW-1:0] res_val,
  input  logic          upd_v,
  input  logic          in_v,
  input  logic          arith_op,
  input  logic          bit_test,
  input  logic [DW-1:0] bit_opnd,
  input  logic [3:0]    cmd,
  input  logic          irq_entry,
  input  logic          irq_is_brk,
  input  logic          irq_req,
  input  logic          pull_load,
  input  logic [DW-1:0] pull_data,
  output logic [DW-1:0] status,
  output logic [DW-1:0] push_val,
  output logic          irq_ok,
  output logic          flag_c,
  output logic          flag_z,
  output logic          flag_i,
  output logic          flag_d,
  output logic          flag_t,
  output logic          flag_v,
  output logic          flag_n
);
  localparam int W = PSR_W;

  logic [W-1:0] set_mask, clr_mask, set_all, upd_vec, val_vec;

  psr_cmd_decode #(.W(W)) u_dec (
    .cmd      (psr_cmd_e'(cmd)),
    .set_mask (set_mask),
    .clr_mask (clr_mask)
  );

  psr_result_path #(.W(W), .DW(DW)) u_res (
    .dec_mode   (status[B_D]),
    .arith_op   (arith_op),
    .upd_c      (upd_c),
    .in_c       (in_c),
    .upd_zn     (upd_zn),
    .res_val    (res_val),
    .upd_v      (upd_v),
    .in_v       (in_v),
    .bit_test   (bit_test),
    .bit_opnd   (bit_opnd),
    .irq_entry  (irq_entry),
    .irq_is_brk (irq_is_brk),
    .upd_vec    (upd_vec),
    .val_vec    (val_vec)
  );

  always_comb begin
    set_all = set_mask;
    set_all[B_I] = set_mask[B_I] | irq_entry;
  end

  for (genvar g = 0; g < W; g++) begin : g_cell
    psr_flag_cell #(.RST_VAL(PSR_RST[g])) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (pull_load),
      .ld_val  (pull_data[g]),
      .set     (set_all[g]),
      .clr     (clr_mask[g]),
      .upd     (upd_vec[g]),
      .upd_val (val_vec[g]),
      .q       (status[g])
    );
  end

  always_comb begin
    push_val = status;
    if (irq_entry) push_val[B_B] = irq_is_brk;
  end

  assign irq_ok = irq_req & ~status[B_I];
  assign flag_c = status[B_C];
  assign flag_z = status[B_Z];
  assign flag_i = status[B_I];
  assign flag_d = status[B_D];
  assign flag_t = status[B_T];
  assign flag_v = status[B_V];
  assign flag_n = status[B_N];

  AST_RESET_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> status == PSR_RST); // R2
  AST_PULL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    pull_load |=> status == $past(pull_data)); // R11
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_entry && !pull_load) |=> flag_i); // R9
  AST_IRQ_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_entry && !pull_load) |=> status[B_B] == $past(irq_is_brk)); // R9
  AST_DEC_HOLD_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_d && arith_op && !pull_load) |=> $stable(flag_z)); // R6
  AST_BIT_NV: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_test && !pull_load) |=> flag_n == $past(bit_opnd[DW-1])); // R7
  AST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    flag_i |-> !irq_ok); // R10
endmodule

// File: tb/tb_psr_flags.sv
module tb_psr_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_c = 0, in_c = 0, upd_zn = 0, upd_v = 0, in_v = 0, arith_op = 0;
  logic       bit_test = 0, irq_entry = 0, irq_is_brk = 0, irq_req = 0, pull_load = 0;
  logic [7:0] res_val = 0, bit_opnd = 0, pull_data = 0;
  logic [3:0] cmd = 0;
  logic [7:0] status, push_val;
  logic       irq_ok, flag_c, flag_z, flag_i, flag_d, flag_t, flag_v, flag_n;
  logic [7:0] model;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  psr_flags dut (
    .clk(clk), .rst_n(rst_n), .upd_c(upd_c), .in_c(in_c), .upd_zn(upd_zn),
    .res_val(res_val), .upd_v(upd_v), .in_v(in_v), .arith_op(arith_op),
    .bit_test(bit_test), .bit_opnd(bit_opnd), .cmd(cmd), .irq_entry(irq_entry),
    .irq_is_brk(irq_is_brk), .irq_req(irq_req), .pull_load(pull_load),
    .pull_data(pull_data), .status(status), .push_val(push_val), .irq_ok(irq_ok),
    .flag_c(flag_c), .flag_z(flag_z), .flag_i(flag_i), .flag_d(flag_d),
    .flag_t(flag_t), .flag_v(flag_v), .flag_n(flag_n)
  );

  function automatic logic [7:0] ref_next(input logic [7:0] s);
    logic [7:0] n;
    logic gate;
    n = s;
    gate = s[3] & arith_op;
    if (pull_load) return pull_data;                              // R11
    if (cmd == 4'd1) n[0] = 1'b1;                                 // R8
    else if (cmd == 4'd2) n[0] = 1'b0;
    else if (upd_c) n[0] = in_c;                                  // R4
    if (upd_zn && !gate) n[1] = (res_val == 8'h00);               // R3
    if (irq_entry || cmd == 4'd3) n[2] = 1'b1;                    // R9
    else if (cmd == 4'd4) n[2] = 1'b0;
    if (cmd == 4'd5) n[3] = 1'b1;
    else if (cmd == 4'd6) n[3] = 1'b0;
    if (irq_entry) n[4] = irq_is_brk;
    if (cmd == 4'd7) n[5] = 1'b1;
    else if (cmd == 4'd8) n[5] = 1'b0;
    if (cmd == 4'd9) n[6] = 1'b0;
    else if (bit_test) n[6] = bit_opnd[6];                        // R7
    else if (upd_v && !gate) n[6] = in_v;                         // R5, R6
    if (bit_test) n[7] = bit_opnd[7];
    else if (upd_zn && !gate) n[7] = res_val[7];
    return n;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    upd_c = 0; upd_zn = 0; upd_v = 0; arith_op = 0; bit_test = 0;
    irq_entry = 0; irq_is_brk = 0; irq_req = 0; pull_load = 0; cmd = 0;
  endtask

  // drive at negedge, check combinational outputs, advance model, compare at next negedge
  task automatic step(input string req);
    #1;
    check8({req, " push_val R9"}, push_val,
           irq_entry ? {model[7:5], irq_is_brk, model[3:0]} : model);
    check8("irq_ok R10", {7'd0, irq_ok}, {7'd0, irq_req & ~model[2]});
    model = ref_next(model);
    @(negedge clk);
    check8({req, " status"}, status, model);
    check8("flag pins R1", {flag_n, flag_v, status[5:4], flag_d, flag_i, flag_z, flag_c},
           {flag_n, flag_v, flag_t, status[4], flag_d, flag_i, flag_z, flag_c});
    check8("flag map R1", {flag_n, flag_v, flag_t, flag_d, flag_i, flag_z, flag_c},
           {status[7:5], status[3:0]});
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check8("reset R2", status, 8'h04);
    rst_n = 1'b1;
    model = 8'h04;
    @(negedge clk);
    check8("after reset R2", status, 8'h04);

    // R3: zero result, negative result
    idle(); upd_zn = 1; res_val = 8'h00; step("R3 zero");
    idle(); upd_zn = 1; res_val = 8'h80; step("R3 negative");
    // R4 carry and R8 commands
    idle(); upd_c = 1; in_c = 1; step("R4 carry");
    idle(); cmd = 4'd2; upd_c = 1; in_c = 1; step("R8 clr beats alu");
    // R6 decimal gating
    idle(); cmd = 4'd5; step("R8 set decimal");
    idle(); arith_op = 1; upd_zn = 1; res_val = 8'h00; upd_v = 1; in_v = 1;
    upd_c = 1; in_c = 0; step("R6 decimal hold");
    idle(); upd_zn = 1; res_val = 8'h00; step("R6 transfer still updates");
    // R7 bit test over ALU
    idle(); bit_test = 1; bit_opnd = 8'h40; upd_zn = 1; res_val = 8'h80; step("R7 bit test");
    idle(); cmd = 4'd9; bit_test = 1; bit_opnd = 8'hC0; step("R8 clrv beats bit test");
    // R8 undefined code
    idle(); cmd = 4'd15; step("R8 undefined code");
    // R9 / R10
    idle(); cmd = 4'd4; step("R8 clear mask");
    idle(); irq_req = 1; step("R10 accept");
    idle(); irq_entry = 1; irq_is_brk = 0; cmd = 4'd4; irq_req = 1; step("R9 hw irq");
    idle(); irq_entry = 1; irq_is_brk = 1; step("R9 brk");
    // R11 pull beats everything
    idle(); pull_load = 1; pull_data = 8'h3B; irq_entry = 1; cmd = 4'd3;
    bit_test = 1; bit_opnd = 8'hFF; step("R11 pull");

    for (int k = 0; k < 3000; k++) begin
      idle();
      upd_c      = ($urandom_range(0, 3) == 0);
      in_c       = $urandom_range(0, 1);
      upd_zn     = ($urandom_range(0, 2) == 0);
      res_val    = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      upd_v      = ($urandom_range(0, 3) == 0);
      in_v       = $urandom_range(0, 1);
      arith_op   = $urandom_range(0, 1);
      bit_test   = ($urandom_range(0, 7) == 0);
      bit_opnd   = 8'($urandom);
      cmd        = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'd0;
      irq_entry  = ($urandom_range(0, 9) == 0);
      irq_is_brk = $urandom_range(0, 1);
      irq_req    = $urandom_range(0, 1);
      pull_load  = ($urandom_range(0, 15) == 0);
      pull_data  = 8'($urandom);
      step("random R1-mix R3 R4 R5 R6 R7 R8 R9 R11");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule